// File: doc/BRIEF.md
# Pipelined Burst Static Memory with Byte Lanes

This block is a synthesizable behavioural model of a synchronous pipelined static memory. Each word is 18 bits wide and is split into two 9-bit lanes. The array depth is set by a parameter. Either of two active-low address strobes can open an access. The processor strobe always opens a read. The controller strobe opens a read or a write, and the write enables sampled on that same edge make the choice. After an access opens, a 2-bit burst counter steps the low address bits, in linear or interleaved order.

Read data travels through a single output register, and `drive_en` tells the board logic when the data pins should be driven. Writes can use a global write that covers the whole word, or per-lane strobes gated by a byte-write enable. Any lane strobe sampled low turns output drive off. A deselect during a read leaves drive on for two more cycles before it falls.

Top module: `burst_ssram`

## Requirements
- R1: An edge with `proc_strobe_n` low and all three chip enables active (`cs_main_n`=0, `cs_hi`=1, `cs_aux_n`=0) registers `addr` and opens a read. No array location is written on that edge, whatever `all_wr_n`, `byte_wr_en_n`, `lane_wr_n` and `ctrl_strobe_n` are doing.
- R2: Data for the address registered on edge k appears on `rdata` after edge k+1. `drive_en` is then high while `out_en_n` is low.
- R3: An edge that writes with `all_wr_n` low stores all 18 bits of `wdata`, whatever the lane strobes are.
- R4: With `all_wr_n` high and `byte_wr_en_n` low, only the lanes whose `lane_wr_n` bit is low are written. Bit 0 selects lane 0 = bits 8:0 and bit 1 selects lane 1 = bits 17:9. With `byte_wr_en_n` high, the lane strobes write nothing.
- R5: An edge with `proc_strobe_n` high, `ctrl_strobe_n` low and all chip enables active registers `addr`. On that same edge it writes the selected lanes at `addr`, or opens a read if no lane is selected.
- R6: Any edge that samples `proc_strobe_n` high and any `lane_wr_n` bit low forces `drive_en` low after that edge, even with `out_en_n` low.
- R7: On an edge that neither starts nor deselects, while a burst is open, `burst_next_n` low steps the burst address and the access on that edge uses the new address. `burst_next_n` high holds the address.
- R8: The burst changes only the two low address bits. If the start bits are s and n is the step count, the low bits are (s+n) mod 4 when `linear_order`=1 and s XOR n when `linear_order`=0.
- R9: A deselect edge k ends the burst. This is `ctrl_strobe_n` low with the enables not all active, or `proc_strobe_n` low with `cs_main_n` low but another enable inactive. If a read was in progress at edge k, `drive_en` stays high after edges k and k+1 and falls after edge k+2.
- R10: An edge with `proc_strobe_n` low while `cs_main_n` is high is ignored: the open burst continues at its current address.
- R11: `out_en_n` high holds `drive_en` low immediately, without waiting for a clock edge.
- R12: After `rst_n` is released, `drive_en` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address sampled by a starting strobe |
| proc_strobe_n | input | 1 | Processor address strobe, active low, read only |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low, read or write |
| burst_next_n | input | 1 | Active-low burst advance |
| linear_order | input | 1 | 1: linear burst order, 0: interleaved |
| cs_main_n | input | 1 | Master chip enable, active low |
| cs_hi | input | 1 | Chip enable, active high |
| cs_aux_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| all_wr_n | input | 1 | Global write of the full word, active low |
| byte_wr_en_n | input | 1 | Enables the lane strobes, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| drive_en | output | 1 | High when the data pins should be driven |

## Verification
The hardest state to reach is the deselect tail. Drive has to be on from a running read, and the deselect must arrive through a strobe while one enable is inactive. The lane strobes must then stay high for the next two edges, or the drive kill hides the tail. The bench first opens a read with the processor strobe and lets it run for one idle edge. It then deselects with the controller strobe while `cs_hi` is low, and samples `drive_en` after each of the next three edges. Burst order is covered by starting mid-group at low bits 01 in both modes and stepping past the wrap.

// File: rtl/burst_ssram.sv
module burst_ssram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      proc_strobe_n,
  input  logic                      ctrl_strobe_n,
  input  logic                      burst_next_n,
  input  logic                      linear_order,
  input  logic                      cs_main_n,
  input  logic                      cs_hi,
  input  logic                      cs_aux_n,
  input  logic                      out_en_n,
  input  logic                      all_wr_n,
  input  logic                      byte_wr_en_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      drive_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dout_q;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic              active, rd_pend, drv_q, tail;

  function automatic logic [1:0] order(input logic [1:0] s, input logic [1:0] n, input logic lin);
    return lin ? 2'(s + n) : (s ^ n);
  endfunction

  wire m_on    = !cs_main_n;
  wire rest_on = cs_hi && !cs_aux_n;
  wire start_p = !proc_strobe_n && m_on && rest_on;
  wire p_desel = !proc_strobe_n && m_on && !rest_on;
  wire start_c = proc_strobe_n && !ctrl_strobe_n && m_on && rest_on;
  wire c_desel = proc_strobe_n && !ctrl_strobe_n && !(m_on && rest_on);
  wire start   = start_p || start_c;
  wire desel   = p_desel || c_desel;
  wire cont    = active && !start && !desel;
  wire step_now = cont && !burst_next_n;

  wire [1:0] cnt_nx = 2'(cnt + 2'd1);
  wire [ADDR_W-1:0] cur = {base[ADDR_W-1:2], order(base[1:0], cnt, linear_order)};
  wire [ADDR_W-1:0] nxt = {base[ADDR_W-1:2], order(base[1:0], cnt_nx, linear_order)};
  wire [ADDR_W-1:0] eff = start_c ? addr : (step_now ? nxt : cur);

  wire [LANES-1:0] wr_lanes = !all_wr_n ? {LANES{1'b1}} : (~lane_wr_n & {LANES{!byte_wr_en_n}});
  wire wr_go   = (start_c || cont) && (|wr_lanes);
  wire kill    = proc_strobe_n && !(&lane_wr_n);
  wire rd_next = start_p || ((start_c || cont) && !(|wr_lanes));

  always_ff @(posedge clk) begin
    for (int g = 0; g < LANES; g++)
      if (wr_go && wr_lanes[g]) mem[eff][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; rd_pend <= 1'b0; drv_q <= 1'b0; tail <= 1'b0;
      base <= '0; cnt <= '0; dout_q <= '0;
    end else begin
      if (rd_pend) dout_q <= mem[cur];
      rd_pend <= rd_next;
      if (start) begin
        active <= 1'b1; base <= addr; cnt <= '0;
      end else if (desel) begin
        active <= 1'b0;
      end else if (step_now) begin
        cnt <= cnt_nx;
      end
      if (kill) begin
        drv_q <= 1'b0; tail <= 1'b0;
      end else if (rd_pend) begin
        drv_q <= 1'b1; tail <= desel;
      end else begin
        tail <= 1'b0;
        if (!tail) drv_q <= 1'b0;
      end
    end
  end

  assign rdata    = dout_q;
  assign drive_en = drv_q && !out_en_n;

  AST_PROC_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n) start_p |=> rd_pend); // R1
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_pend |=> $stable(dout_q)); // R2
  AST_LANE_KILLS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (proc_strobe_n && !(&lane_wr_n)) |=> !drive_en); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cont && burst_next_n) |=> $stable(cnt)); // R7
  AST_DESEL_TAIL: assert property (@(posedge clk) disable iff (!rst_n) (desel && rd_pend && (!proc_strobe_n || (&lane_wr_n))) |=> drv_q); // R9
endmodule

// File: tb/burst_ssram_tb.sv
`timescale 1ns/1ps
module burst_ssram_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic proc_n, ctrl_n, adv_n, lin, cs_m_n, cs_h, cs_a_n, oe_n, gw_n, bwe_n;
  logic [1:0] lane_n;
  logic [17:0] wdata, rdata;
  logic drive_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_ssram u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strobe_n(proc_n), .ctrl_strobe_n(ctrl_n),
    .burst_next_n(adv_n), .linear_order(lin), .cs_main_n(cs_m_n), .cs_hi(cs_h), .cs_aux_n(cs_a_n),
    .out_en_n(oe_n), .all_wr_n(gw_n), .byte_wr_en_n(bwe_n), .lane_wr_n(lane_n),
    .wdata(wdata), .rdata(rdata), .drive_en(drive_en));

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    proc_n = 1; ctrl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; lane_n = 2'b11;
    cs_m_n = 0; cs_h = 1; cs_a_n = 0; oe_n = 0; wdata = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [17:0] d);
    idle(); addr = a; ctrl_n = 0; gw_n = 0; wdata = d; step(); idle();
  endtask

  task automatic rd(input logic [9:0] a, input logic [17:0] exp, input string tag);
    idle(); addr = a; proc_n = 0; step(); idle(); step();
    chk({tag, " R2 rdata"}, rdata, exp);
    chk({tag, " R2 drive"}, 18'(drive_en), 18'd1);
  endtask

  task automatic t_global();
    wr(10'h005, 18'h0);
    idle(); addr = 10'h005; ctrl_n = 0; gw_n = 0; bwe_n = 1; lane_n = 2'b11; wdata = 18'h2AAAA; step();
    rd(10'h005, 18'h2AAAA, "R3 R5 global write");
  endtask

  task automatic t_bytes();
    wr(10'h030, 18'h0);
    idle(); addr = 10'h030; ctrl_n = 0; bwe_n = 0; lane_n = 2'b10; wdata = 18'h3FFFF; step();
    rd(10'h030, 18'h001FF, "R4 lane0 only");
    idle(); addr = 10'h030; ctrl_n = 0; bwe_n = 1; lane_n = 2'b00; wdata = 18'h0; step();
    rd(10'h030, 18'h001FF, "R4 enable off ignored");
    idle(); addr = 10'h030; ctrl_n = 0; bwe_n = 0; lane_n = 2'b01; wdata = 18'h14A00; step();
    rd(10'h030, 18'h14BFF, "R4 lane1 only");
  endtask

  task automatic t_proc_read();
    wr(10'h007, 18'h12345);
    idle(); addr = 10'h007; proc_n = 0; ctrl_n = 0; gw_n = 0; bwe_n = 0; lane_n = 2'b00; wdata = 18'h3FFFF;
    step(); idle(); step();
    chk("R1 proc start never writes", rdata, 18'h12345);
  endtask

  task automatic t_kill();
    rd(10'h007, 18'h12345, "R6 setup");
    idle(); lane_n = 2'b10; step();
    chk("R6 lane low kills drive", 18'(drive_en), 18'd0);
    idle(); step();
    chk("R6 drive returns", 18'(drive_en), 18'd1);
  endtask

  task automatic t_burst(input logic mode);
    for (int i = 0; i < 4; i++) wr(10'(10'h010 + i), 18'(18'h3010 + i));
    idle(); lin = mode; addr = 10'h011; proc_n = 0; step();
    idle(); adv_n = 0;
    for (int n = 0; n < 4; n++) begin
      step();
      chk(mode ? "R8 R7 linear step" : "R8 R7 interleaved step", rdata,
          18'(18'h3010 + (mode ? ((1 + n) & 3) : (1 ^ n))));
    end
    adv_n = 1;
    step(); step();
    chk("R7 hold on advance high", rdata, 18'h3011);
  endtask

  task automatic t_write_burst();
    lin = 1;
    idle(); addr = 10'h020; ctrl_n = 0; gw_n = 0; wdata = 18'h0AAA0; step();
    idle(); gw_n = 0; adv_n = 0; wdata = 18'h0AAA1; step();
    idle(); bwe_n = 0; lane_n = 2'b00; adv_n = 0; wdata = 18'h0AAA2; step();
    idle(); step();
    rd(10'h020, 18'h0AAA0, "R5 burst word0");
    rd(10'h021, 18'h0AAA1, "R7 burst word1");
    rd(10'h022, 18'h0AAA2, "R7 burst word2");
  endtask

  task automatic t_desel();
    rd(10'h022, 18'h0AAA2, "R9 setup");
    idle(); ctrl_n = 0; cs_h = 0; step();
    chk("R9 drive after deselect edge", 18'(drive_en), 18'd1);
    idle(); step();
    chk("R9 drive one edge later", 18'(drive_en), 18'd1);
    step();
    chk("R9 drive falls", 18'(drive_en), 18'd0);
  endtask

  task automatic t_master();
    lin = 1;
    rd(10'h011, 18'h3011, "R10 setup");
    idle(); addr = 10'h012; proc_n = 0; cs_m_n = 1; step();
    idle(); step();
    chk("R10 blocked strobe ignored", rdata, 18'h3011);
    chk("R10 drive kept", 18'(drive_en), 18'd1);
  endtask

  task automatic t_oe();
    rd(10'h011, 18'h3011, "R11 setup");
    oe_n = 1; #1;
    chk("R11 oe high blocks drive", 18'(drive_en), 18'd0);
    oe_n = 0; #1;
    chk("R11 oe low restores", 18'(drive_en), 18'd1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); lin = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset drive low", 18'(drive_en), 18'd0);
    step();
    chk("R12 no burst after reset", 18'(drive_en), 18'd0);
    t_global();
    t_bytes();
    t_proc_read();
    t_kill();
    t_burst(1'b1);
    t_burst(1'b0);
    t_write_burst();
    t_desel();
    t_master();
    t_oe();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule